// File: doc/BRIEF.md
# Test-Under-Mask Instruction Executor

This block carries out one instruction of a small 8-bit register-file controller. The instruction ANDs a destination byte with a mask byte. It reports whether the selected bits are all zero and whether bit 7 of the result is set, and it never writes either operand.

The instruction stream enters one byte at a time over a valid/ready pair. The first byte is the opcode, and it selects one of five operand layouts:

- two working registers packed into nibbles;
- a working register and a pointer through a working register;
- two direct register addresses;
- a direct address and a pointer;
- a direct address and an immediate mask.

All reads go to a 256-byte register file held in the block. Working register n is register-file address 0x0n.

Each legal instruction ends with a one-cycle done pulse that carries its byte length and its cycle count. The register file and the flags register have their own preload write ports. These are used only while no instruction is in flight.

Top module: `tm_exec`

## Requirements
- R1: The flags register holds C at bit 7, Z at bit 6, S at bit 5, V at bit 4, D at bit 3 and H at bit 2. When an instruction completes, Z is 1 exactly when (destination AND mask) is zero.
- R2: When an instruction completes, S equals bit 7 of (destination AND mask).
- R3: When an instruction completes, V is cleared. C, D, H and flag bits 1:0 keep their previous values.
- R4: Opcode 0x72 is 2 bytes long and takes 4 cycles. Its second byte holds the destination working register in bits 7:4 and the mask working register in bits 3:0.
- R5: Opcode 0x73 is 2 bytes long and takes 6 cycles. It uses the same nibble layout as 0x72, but the mask is read from the register whose address is stored in the named working register.
- R6: Opcode 0x74 is 3 bytes long and takes 6 cycles. Byte 2 is the mask register address and byte 3 is the destination register address.
- R7: Opcode 0x75 is 3 bytes long and takes 6 cycles. It has the byte order of 0x74, but the mask is read from the register whose address is stored at the byte-2 address.
- R8: Opcode 0x76 is 3 bytes long and takes 6 cycles. Byte 2 is the destination register address and byte 3 is the immediate mask.
- R9: When the operand bytes arrive without gaps, done is high for exactly one cycle, and it is registered N clock edges after the edge that accepted the opcode (N = the cycle count). During that cycle done_len and done_cycles give the byte length and the cycle count; at all other times they read zero. If operand bytes arrive late, done follows on the edge after the last operand byte is accepted.
- R10: Executing an instruction never modifies the register file, so a repeated instruction gives the same flags.
- R11: Any other opcode leaves the flags unchanged, raises illegal for the one cycle after the opcode edge, and produces no done.
- R12: in_ready is high while idle, and while the current instruction still has operand bytes outstanding. It is low otherwise.
- R13: After reset the flags, done and illegal are zero, in_ready is high, and every register-file byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| rf_we | input | 1 | Register-file preload write enable |
| rf_waddr | input | 8 | Preload address |
| rf_wdata | input | 8 | Preload data |
| flag_we | input | 1 | Flags preload write enable |
| flag_wdata | input | 8 | Flags preload value |
| flags | output | 8 | Status flags register |
| done | output | 1 | One-cycle completion pulse |
| done_len | output | 2 | Instruction byte length, valid with done |
| done_cycles | output | 4 | Instruction cycle count, valid with done |
| illegal | output | 1 | One-cycle unrecognised-opcode pulse |

## Verification
A wrong latched mode or a wrong captured operand byte shows up as a wrong Z or S bit on the done cycle of that same instruction. A cycle counter that is off by one moves done by at least one edge, and a bench that follows the timing cycle by cycle catches this on that edge. A stuck byte counter shows up within a cycle as in_ready staying high or low when it should not. Any write back into the register file would only show up on a later instruction that reads the same address, so the bench repeats instructions on the same registers.

// File: rtl/tm_pkg.sv
// Shared widths, flag positions, modes and decode record for the
// test-under-mask executor. Assumes an 8-bit datapath and a 256-entry file.
package tm_pkg;
    localparam int DW      = 8;
    localparam int AW      = 8;
    localparam int NREG    = 1 << AW;
    localparam int NIB     = DW / 2;
    localparam int CYC_W   = 4;
    localparam int LEN_W   = 2;

    localparam int F_C = 7;
    localparam int F_Z = 6;
    localparam int F_S = 5;
    localparam int F_V = 4;
    localparam int F_D = 3;
    localparam int F_H = 2;

    typedef enum logic [2:0] {
        M_WW,   // working reg, working reg
        M_WP,   // working reg, pointer in working reg
        M_AA,   // mask addr, dest addr
        M_AP,   // pointer addr, dest addr
        M_AI    // dest addr, immediate
    } mode_e;

    typedef enum logic {S_IDLE, S_EXEC} state_e;

    typedef struct packed {
        logic             legal;
        mode_e            mode;
        logic [LEN_W-1:0] len;
        logic [CYC_W-1:0] cyc;
    } dec_t;
endpackage

// File: rtl/tm_decode.sv
// Opcode decoder: maps an opcode byte to mode, byte length and cycle count.
// Assumes nothing about timing; purely combinational.
module tm_decode
    import tm_pkg::*;
(
    input  logic [DW-1:0] opc,
    output dec_t          dec
);
    // Table of the five supported encodings; everything else is illegal.
    always_comb begin
        dec = '{legal: 1'b0, mode: M_WW, len: '0, cyc: '0};
        case (opc)
            8'h72: dec = '{legal: 1'b1, mode: M_WW, len: 2'd2, cyc: 4'd4};
            8'h73: dec = '{legal: 1'b1, mode: M_WP, len: 2'd2, cyc: 4'd6};
            8'h74: dec = '{legal: 1'b1, mode: M_AA, len: 2'd3, cyc: 4'd6};
            8'h75: dec = '{legal: 1'b1, mode: M_AP, len: 2'd3, cyc: 4'd6};
            8'h76: dec = '{legal: 1'b1, mode: M_AI, len: 2'd3, cyc: 4'd6};
            default: ;
        endcase
    end
endmodule

// File: rtl/tm_regfile.sv
// Register file with one preload write port and NRD asynchronous read ports.
// Assumes writes happen only while no instruction is executing.
module tm_regfile
    import tm_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [NRD*AW-1:0] raddr,
    output logic [NRD*DW-1:0] rdata
);
    logic [DW-1:0] mem [NREG];

    // Clear on reset, otherwise accept preload writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Combinational read port p.
        assign rdata[p*DW +: DW] = mem[raddr[p*AW +: AW]];
    end
endmodule

// File: rtl/tm_flagcalc.sv
// Flag update for test-under-mask: Z and S from the AND, V cleared,
// all other bits passed through. Combinational.
module tm_flagcalc
    import tm_pkg::*;
(
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] mask,
    input  logic [7:0]    old_flags,
    output logic [7:0]    new_flags
);
    logic [DW-1:0] res;

    // Form the masked result and merge it into the previous flags.
    always_comb begin
        res            = dst & mask;
        new_flags      = old_flags;
        new_flags[F_Z] = (res == '0);
        new_flags[F_S] = res[DW-1];
        new_flags[F_V] = 1'b0;
    end
endmodule

// File: rtl/tm_exec.sv
// Test-under-mask executor top. Accepts an opcode and its operand bytes,
// waits the encoding's cycle count, then updates the flags and pulses done.
// Assumes the preload ports are quiet while an instruction is in flight.
module tm_exec
    import tm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    input  logic             rf_we,
    input  logic [7:0]       rf_waddr,
    input  logic [7:0]       rf_wdata,
    input  logic             flag_we,
    input  logic [7:0]       flag_wdata,
    output logic [7:0]       flags,
    output logic             done,
    output logic [1:0]       done_len,
    output logic [3:0]       done_cycles,
    output logic             illegal
);
    localparam int NRD = 3;

    state_e           state_q;
    dec_t             dec_in, dec_q;
    logic [1:0]       got_q;
    logic [1:0]       need;
    logic [DW-1:0]    b1_q, b2_q;
    logic [CYC_W-1:0] cnt_q;
    logic [7:0]       flags_q, flags_nx;
    logic             done_q, ill_q;
    logic [LEN_W-1:0] len_q;
    logic [CYC_W-1:0] cyc_q;
    logic             accept, fire;

    logic [AW-1:0]     dst_addr, ptr_addr;
    logic [DW-1:0]     dst_val, ptr_val, ind_val, mask_val;
    logic [NRD*AW-1:0] raddr;
    logic [NRD*DW-1:0] rdata;

    tm_decode u_dec (.opc(in_byte), .dec(dec_in));

    tm_regfile #(.NRD(NRD)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
        .wdata(rf_wdata), .raddr(raddr), .rdata(rdata)
    );

    tm_flagcalc u_fl (
        .dst(dst_val), .mask(mask_val), .old_flags(flags_q), .new_flags(flags_nx)
    );

    // Handshake and completion conditions.
    always_comb begin
        need     = dec_q.len - 2'd1;
        in_ready = (state_q == S_IDLE) || (got_q < need);
        accept   = in_valid && in_ready;
        fire     = (state_q == S_EXEC) && (cnt_q == dec_q.cyc) && (got_q == need);
    end

    // Operand address selection per mode; port 2 chases port 1 for pointers.
    always_comb begin
        case (dec_q.mode)
            M_WW, M_WP: begin
                dst_addr = {{(AW-NIB){1'b0}}, b1_q[DW-1:NIB]};
                ptr_addr = {{(AW-NIB){1'b0}}, b1_q[NIB-1:0]};
            end
            M_AA, M_AP: begin
                dst_addr = b2_q;
                ptr_addr = b1_q;
            end
            default: begin
                dst_addr = b1_q;
                ptr_addr = b1_q;
            end
        endcase
        raddr    = {ptr_val, ptr_addr, dst_addr};
        dst_val  = rdata[0*DW +: DW];
        ptr_val  = rdata[1*DW +: DW];
        ind_val  = rdata[2*DW +: DW];
        case (dec_q.mode)
            M_WW, M_AA: mask_val = ptr_val;
            M_WP, M_AP: mask_val = ind_val;
            default:    mask_val = b2_q;
        endcase
    end

    // Sequencer: opcode capture, operand collection, cycle count, flag write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dec_q   <= '{legal: 1'b0, mode: M_WW, len: 2'd2, cyc: '0};
            got_q   <= '0;
            b1_q    <= '0;
            b2_q    <= '0;
            cnt_q   <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
            len_q   <= '0;
            cyc_q   <= '0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            if (flag_we) flags_q <= flag_wdata;
            case (state_q)
                S_IDLE: begin
                    if (in_valid) begin
                        if (dec_in.legal) begin
                            dec_q   <= dec_in;
                            state_q <= S_EXEC;
                            cnt_q   <= 4'd1;
                            got_q   <= '0;
                        end else begin
                            ill_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (fire) begin
                        flags_q <= flags_nx;
                        done_q  <= 1'b1;
                        len_q   <= dec_q.len;
                        cyc_q   <= dec_q.cyc;
                        state_q <= S_IDLE;
                    end else begin
                        if (cnt_q != dec_q.cyc) cnt_q <= cnt_q + 4'd1;
                        if (accept) begin
                            if (got_q == 2'd0) b1_q <= in_byte;
                            else               b2_q <= in_byte;
                            got_q <= got_q + 2'd1;
                        end
                    end
                end
            endcase
        end
    end

    assign flags       = flags_q;
    assign done        = done_q;
    assign illegal     = ill_q;
    assign done_len    = done_q ? len_q : '0;
    assign done_cycles = done_q ? cyc_q : '0;

    AST_V_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !flags_q[F_V]); // R3
    AST_CDH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (flags_q[F_C] == $past(flags_q[F_C])) &&
                   (flags_q[F_D] == $past(flags_q[F_D])) &&
                   (flags_q[F_H] == $past(flags_q[F_H]))); // R3
    AST_ILL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_q && !$past(flag_we)) |-> $stable(flags_q)); // R11
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_q, ill_q})); // R11
    AST_DONE_FROM_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(state_q) == S_EXEC)); // R9
    AST_LEN_CYC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((done_len == 2'd2 && (done_cycles == 4'd4 || done_cycles == 4'd6)) ||
                    (done_len == 2'd3 && done_cycles == 4'd6))); // R9
endmodule

// File: tb/sim_tm_exec.sv
module sim_tm_exec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ready;
    logic       rf_we = 1'b0;
    logic [7:0] rf_waddr = '0, rf_wdata = '0;
    logic       flag_we = 1'b0;
    logic [7:0] flag_wdata = '0;
    logic [7:0] flags;
    logic       done, illegal;
    logic [1:0] done_len;
    logic [3:0] done_cycles;

    int tests = 0, fails = 0, cyc_cnt = 0, t0 = 0;

    always #4 clk = ~clk;

    tm_exec u0 (.*);

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Reference model state, advanced on every rising edge.
    int         m_busy, m_need, m_cnt, m_cyc, m_len, m_opc;
    int         q[$];
    logic [7:0] m_rf [256];
    logic [7:0] m_fl;
    int         e_done, e_ill, e_len, e_cyc;

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_fl = 0; q.delete();
            e_done = 0; e_ill = 0; e_len = 0; e_cyc = 0;
            for (int i = 0; i < 256; i++) m_rf[i] = 0;
        end else begin
            int fire;
            e_done = 0; e_ill = 0; e_len = 0; e_cyc = 0;
            fire = m_busy && m_cnt >= m_cyc && q.size() == m_need;
            if (flag_we) m_fl = flag_wdata;
            if (m_busy) begin
                if (fire) begin
                    int d, k, r;
                    case (m_opc)
                        'h72: begin d = m_rf[q[0] / 16]; k = m_rf[q[0] % 16]; end
                        'h73: begin d = m_rf[q[0] / 16]; k = m_rf[m_rf[q[0] % 16]]; end
                        'h74: begin d = m_rf[q[1]]; k = m_rf[q[0]]; end
                        'h75: begin d = m_rf[q[1]]; k = m_rf[m_rf[q[0]]]; end
                        default: begin d = m_rf[q[0]]; k = q[1]; end
                    endcase
                    r = d & k;
                    m_fl[6] = (r == 0);
                    m_fl[5] = (r >= 128);
                    m_fl[4] = 0;
                    m_busy = 0; e_done = 1; e_len = m_len; e_cyc = m_cyc;
                end else begin
                    m_cnt++;
                    if (in_valid && q.size() < m_need) q.push_back(int'(in_byte));
                end
            end else if (in_valid) begin
                case (in_byte)
                    8'h72: begin m_len = 2; m_cyc = 4; end
                    8'h73: begin m_len = 2; m_cyc = 6; end
                    8'h74, 8'h75, 8'h76: begin m_len = 3; m_cyc = 6; end
                    default: m_len = 0;
                endcase
                if (m_len != 0) begin
                    m_busy = 1; m_opc = in_byte; m_cnt = 1;
                    m_need = m_len - 1; q.delete();
                end else e_ill = 1;
            end
            if (rf_we) m_rf[rf_waddr] = rf_wdata;
        end
    end

    // Every-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 flags vs model", flags, m_fl);
            check("R9 done vs model", done, e_done);
            check("R9 done_len vs model", done_len, e_len);
            check("R9 done_cycles vs model", done_cycles, e_cyc);
            check("R11 illegal vs model", illegal, e_ill);
            check("R12 in_ready vs model", in_ready,
                  (m_busy == 0 || q.size() < m_need) ? 1 : 0);
        end
    end

    task automatic wr(input int a, input int d);
        rf_we = 1; rf_waddr = a[7:0]; rf_wdata = d[7:0];
        @(negedge clk);
        rf_we = 0;
    endtask

    task automatic push(input int b);
        in_valid = 1; in_byte = b[7:0];
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_done(input string tag, input int n, input int gap_ok);
        int lim = 0;
        while (!done && lim < 50) begin @(negedge clk); lim++; end
        check({tag, " done seen"}, done, 1);
        if (!gap_ok) check({tag, " R9 latency"}, cyc_cnt - t0, n);
    endtask

    task automatic run(input string tag, input int opc, input int a, input int b,
                       input int len, input int n, input int exp_fl);
        push(opc);
        t0 = cyc_cnt;
        push(a);
        if (len == 3) push(b);
        in_valid = 0;
        wait_done(tag, n, 0);
        check({tag, " length"}, done_len, len);
        check({tag, " cycles"}, done_cycles, n);
        check({tag, " flags"}, flags, exp_fl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R13 flags after reset", flags, 0);
        check("R13 done after reset", done, 0);
        check("R13 illegal after reset", illegal, 0);
        check("R13 in_ready after reset", in_ready, 1);
        // R13: zeroed file gives a zero result
        run("R13 zeroed file", 'h72, 'h01, 0, 2, 4, 'h40);

        wr('h00, 'hC7); wr('h01, 'h02); wr('h02, 'h23);
        wr('h20, 'h2B); wr('h21, 'h02); wr('h30, 'hF0); wr('h31, 'h80);
        flag_we = 1; flag_wdata = 8'h9F; @(negedge clk); flag_we = 0;

        run("R4 nibble regs", 'h72, 'h01, 0, 2, 4, 'h8F);
        run("R5 nibble pointer", 'h73, 'h01, 0, 2, 6, 'h8F);
        run("R6 direct src-first", 'h74, 'h21, 'h20, 3, 6, 'h8F);
        run("R7 pointer src-first", 'h75, 'h21, 'h20, 3, 6, 'h8F);
        run("R8 immediate zero R1", 'h76, 'h20, 'h54, 3, 6, 'hCF);
        run("R2 sign bit", 'h76, 'h30, 'h80, 3, 6, 'hAF);
        check("R3 V cleared", flags[4], 0);
        check("R3 C D H kept", {flags[7], flags[3], flags[2]}, 3'b111);

        // R11: unknown opcode
        push('h55);
        in_valid = 0;
        check("R11 illegal pulse", illegal, 1);
        check("R11 flags unchanged", flags, 'hAF);
        @(negedge clk);
        check("R11 illegal one cycle", illegal, 0);
        check("R11 no done", done, 0);

        // R9: operand bytes delayed
        push('h74);
        in_valid = 0;
        repeat (4) @(negedge clk);
        check("R12 ready while waiting operands", in_ready, 1);
        push('h31); push('h30);
        in_valid = 0;
        wait_done("R9 gapped", 6, 1);
        check("R9 gapped flags", flags, 'hAF);

        // R10: repeats on the same registers give the same result
        run("R10 repeat nibble", 'h72, 'h01, 0, 2, 4, 'h8F);
        run("R10 repeat pointer", 'h75, 'h21, 'h20, 3, 6, 'h8F);

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule